// File: doc/BRIEF.md
# Chainable Synchronous Binary Counter

This block is a synchronous up-counter made of equal 4-bit slices joined into one wider counter. A 4-bit slice can load a data word in parallel, clear itself, and count up by one. It counts only when its two enables are both high: a parallel enable shared by every slice and a trickle enable that is local to the slice. Each slice drives a terminal-count flag. The flag is high when the slice holds all ones and its trickle enable is high.

The wrapper uses these flags to build a counter of any width. The trickle enable of each slice is driven by the terminal-count flag of the slice below it. The bottom slice takes the top-level trickle enable. Every slice shares one clock, so all counter bits change on the same edge and no carry ripples through the clock path.

Clear, load and count act only on the rising clock edge. When more than one is active, clear wins over load and load wins over count. A synchronous clear driven from a decode of the count gives a shorter counting cycle. An asynchronous active-low reset, released synchronously, puts the counter at zero at power-up.

Top module: `sync_count_chain`

## Requirements
- R1: While `rst_n` is low, `count` is zero without waiting for a clock edge. After `rst_n` rises, the counter stays at zero and ignores clear, load and count for two more rising edges.
- R2: If `clear_n` is low at a rising edge, `count` becomes zero on that edge. The levels of `load_n`, `par_en` and `trk_en` make no difference.
- R3: If `clear_n` is high and `load_n` is low at a rising edge, `count` takes the value of `load_data` on that edge. The enable levels make no difference.
- R4: If `clear_n` and `load_n` are both high, `count` goes up by one at a rising edge only when `par_en` and `trk_en` are both high. Otherwise `count` keeps its value.
- R5: Counting up from the all-ones value gives zero.
- R6: A slice's terminal-count flag is high exactly when that slice holds all ones and its trickle enable is high. `par_en` has no effect on the flag.
- R7: The chain counts as one binary counter of `SLICE_W*NUM_SLICES` bits. Slice k counts only when every slice below it holds all ones. `term_out` is high only when the whole `count` is all ones and `trk_en` is high.
- R8: `term_out` is combinational from the current `count` and `trk_en`. It rises in the same cycle that `count` reaches all ones, and with `trk_en` held high it stays high for exactly one clock period while counting.
- R9: If `clear_n` is driven low while `count` equals M, counting runs through 0..M and then returns to 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clear_n | input | 1 | Active-low synchronous clear |
| load_n | input | 1 | Active-low synchronous parallel load |
| load_data | input | SLICE_W*NUM_SLICES | Value written on a load |
| par_en | input | 1 | Parallel count enable, shared by every slice |
| trk_en | input | 1 | Trickle enable into the bottom slice |
| count | output | SLICE_W*NUM_SLICES | Counter value |
| term_out | output | 1 | Terminal-count flag of the top slice |

## Verification
The bench drives clear and load together with both enables high. A design with the priority wrong would load or count when it should clear, or count when it should load. It loads values just below a slice boundary and values that are all ones in only some slices. A carry chain that tests only the bottom slice would advance an upper slice too early or raise `term_out` at a value that is not the maximum. It checks `term_out` in the same cycle that all ones appears, with `par_en` low, and across the wrap to zero. A registered or wrongly gated flag would then show up a cycle late or follow `par_en`. Decode-driven clears for several values of M check that the shortened cycle ends at exactly M.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  // Operation a slice performs on the next rising edge, highest priority first.
  typedef enum logic [1:0] {
    OP_CLEAR = 2'd0,
    OP_LOAD  = 2'd1,
    OP_COUNT = 2'd2,
    OP_HOLD  = 2'd3
  } slice_op_e;
endpackage

// File: rtl/cnt_rst_sync.sv
module cnt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cnt_slice.sv
module cnt_slice
  import cnt_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_n,
  input  logic         load_n,
  input  logic [W-1:0] din,
  input  logic         en_par,
  input  logic         en_trk,
  output logic [W-1:0] q,
  output logic         tc
);
  localparam logic [W-1:0] TOP_VAL = {W{1'b1}};

  slice_op_e    op;
  logic [W-1:0] q_nxt;
  logic         q_en;

  // Fixed priority: clear, then load, then count.
  always_comb begin
    if (!clear_n)                op = OP_CLEAR;
    else if (!load_n)            op = OP_LOAD;
    else if (en_par && en_trk)   op = OP_COUNT;
    else                         op = OP_HOLD;
  end

  always_comb begin
    case (op)
      OP_CLEAR: q_nxt = '0;
      OP_LOAD:  q_nxt = din;
      OP_COUNT: q_nxt = q + 1'b1;
      default:  q_nxt = q;
    endcase
  end

  assign q_en = (op != OP_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_nxt;
  end

  // The flag depends only on the local count and the trickle enable.
  assign tc = en_trk & (q == TOP_VAL);

  assert_clear_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n |=> (q == '0));

  assert_load_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && !load_n) |=> (q == $past(din)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && load_n && !(en_par && en_trk)) |=> $stable(q));

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && load_n && en_par && en_trk) |=> (q == W'($past(q) + 1'b1)));

  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && load_n && en_par && en_trk && q == TOP_VAL) |=> (q == '0));

  assert_tc_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_trk |-> !tc);
endmodule

// File: rtl/sync_count_chain.sv
module sync_count_chain #(
  parameter int SLICE_W    = 4,
  parameter int NUM_SLICES = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clear_n,
  input  logic                          load_n,
  input  logic [SLICE_W*NUM_SLICES-1:0] load_data,
  input  logic                          par_en,
  input  logic                          trk_en,
  output logic [SLICE_W*NUM_SLICES-1:0] count,
  output logic                          term_out
);
  localparam int TOTAL_W = SLICE_W * NUM_SLICES;

  logic                rst_sync_n;
  logic [NUM_SLICES:0] trickle;

  cnt_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign trickle[0] = trk_en;

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    cnt_slice #(.W(SLICE_W)) u_slice (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .clear_n (clear_n),
      .load_n  (load_n),
      .din     (load_data[k*SLICE_W +: SLICE_W]),
      .en_par  (par_en),
      .en_trk  (trickle[k]),
      .q       (count[k*SLICE_W +: SLICE_W]),
      .tc      (trickle[k+1])
    );
  end

  assign term_out = trickle[NUM_SLICES];

  assert_term_at_max_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    term_out |-> (count == {TOTAL_W{1'b1}}));

  assert_chain_step_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clear_n && load_n && par_en && trk_en) |=> (count == TOTAL_W'($past(count) + 1'b1)));

  assert_reset_zero_R1: assert property (@(posedge clk)
    !rst_sync_n |-> (count == '0));
endmodule

// File: tb/tb_sync_count_chain.sv
module tb_sync_count_chain;
  localparam int SW = 4;
  localparam int NS = 3;
  localparam int TW = SW * NS;
  localparam logic [TW-1:0] MAXV = {TW{1'b1}};

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clear_n, load_n, par_en, trk_en;
  logic [TW-1:0] load_data;
  logic [TW-1:0] count;
  logic          term_out;

  int checks = 0;
  int errors = 0;
  logic [TW-1:0] model;

  sync_count_chain #(.SLICE_W(SW), .NUM_SLICES(NS)) dut (
    .clk(clk), .rst_n(rst_n), .clear_n(clear_n), .load_n(load_n),
    .load_data(load_data), .par_en(par_en), .trk_en(trk_en),
    .count(count), .term_out(term_out)
  );

  always #10 clk = ~clk;

  function automatic logic [TW-1:0] next_val(logic [TW-1:0] cur, logic cl_n, logic ld_n,
                                            logic [TW-1:0] d, logic pe, logic te);
    if (!cl_n)           return '0;
    else if (!ld_n)      return d;
    else if (pe && te)   return cur + 1'b1;
    else                 return cur;
  endfunction

  function automatic logic exp_term(logic [TW-1:0] cur, logic te);
    return te && (cur == MAXV);
  endfunction

  task automatic check_cnt(string req, logic [TW-1:0] exp);
    checks++;
    if (count !== exp) begin
      errors++;
      $display("FAIL %s count actual=%h expected=%h", req, count, exp);
    end
  endtask

  task automatic check_term(string req, logic exp);
    checks++;
    if (term_out !== exp) begin
      errors++;
      $display("FAIL %s term_out actual=%b expected=%b", req, term_out, exp);
    end
  endtask

  // Drive on the falling edge, check the flag in the same cycle, then check the count after the rising edge.
  task automatic step(logic cl_n, logic ld_n, logic [TW-1:0] d, logic pe, logic te, string req);
    @(negedge clk);
    clear_n = cl_n; load_n = ld_n; load_data = d; par_en = pe; trk_en = te;
    #1;
    check_term({req, "/R6/R8"}, exp_term(model, te));
    @(posedge clk);
    model = next_val(model, cl_n, ld_n, d, pe, te);
    #1;
    check_cnt(req, model);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; clear_n = 1'b1; load_n = 1'b1; par_en = 1'b1; trk_en = 1'b1;
    load_data = '0; model = '0;
    repeat (3) @(posedge clk);
    #1 check_cnt("R1 reset", '0);
    @(negedge clk) rst_n = 1'b1;
    // For two edges after release the internal reset still holds the counter at zero.
    @(posedge clk); #1 check_cnt("R1 release hold", '0);
    @(posedge clk); #1 check_cnt("R1 release hold", '0);

    // Check the priority order.
    step(1'b0, 1'b0, 12'hABC, 1'b1, 1'b1, "R2 clear over load/enables");
    step(1'b1, 1'b0, 12'h5A3, 1'b0, 1'b0, "R3 load enables low");
    step(1'b1, 1'b0, 12'h123, 1'b1, 1'b1, "R3 load over count");
    step(1'b1, 1'b1, 12'h000, 1'b1, 1'b0, "R4 hold trk low");
    step(1'b1, 1'b1, 12'h000, 1'b0, 1'b1, "R4 hold par low");
    step(1'b1, 1'b1, 12'h000, 1'b1, 1'b1, "R4 count");

    // Carry across slice boundaries.
    step(1'b1, 1'b0, 12'h00E, 1'b0, 1'b0, "R3 load 00E");
    step(1'b1, 1'b1, 12'h000, 1'b1, 1'b1, "R7 to 00F");
    step(1'b1, 1'b1, 12'h000, 1'b1, 1'b1, "R7 carry into slice1");
    check_cnt("R7 carry 010", 12'h010);
    step(1'b1, 1'b0, 12'h0FF, 1'b0, 1'b0, "R3 load 0FF");
    step(1'b1, 1'b1, 12'h000, 1'b1, 1'b1, "R7 carry into slice2");
    check_cnt("R7 carry 100", 12'h100);
    step(1'b1, 1'b0, 12'hF0F, 1'b0, 1'b0, "R3 load F0F");
    step(1'b1, 1'b1, 12'h000, 1'b0, 1'b1, "R7 partial ones no term");

    // Terminal count and wrap.
    step(1'b1, 1'b0, 12'hFFE, 1'b0, 1'b0, "R3 load FFE");
    step(1'b1, 1'b1, 12'h000, 1'b1, 1'b1, "R8 reach max");
    @(negedge clk); par_en = 1'b0; trk_en = 1'b1; #1;
    check_term("R6 par low term high", 1'b1);
    trk_en = 1'b0; #1;
    check_term("R6 trk low term low", 1'b0);
    step(1'b1, 1'b1, 12'h000, 1'b1, 1'b1, "R5 wrap");
    check_cnt("R5 wrap zero", 12'h000);
    step(1'b1, 1'b1, 12'h000, 1'b1, 1'b1, "R8 one period term");

    // Modulus shortened by a decoded clear, for several end values.
    for (int m = 3; m < 12; m += 4) begin
      step(1'b0, 1'b1, 12'h000, 1'b0, 1'b0, "R9 start");
      for (int i = 0; i < 2 * (m + 1); i++) begin
        step(model != TW'(m), 1'b1, 12'h000, 1'b1, 1'b1, "R9 truncated");
        checks++;
        if (model > TW'(m)) begin
          errors++;
          $display("FAIL R9 count actual=%h expected<=%h", count, m);
        end
      end
    end

    // Random sequences checked against the integer model.
    for (int i = 0; i < 3000; i++) begin
      logic cl, ld, pe, te;
      logic [TW-1:0] d;
      cl = ($urandom % 100) >= 4;
      ld = ($urandom % 100) >= 8;
      pe = ($urandom % 100) < 80;
      te = ($urandom % 100) < 85;
      d  = (($urandom % 4) == 0) ? (MAXV - TW'($urandom % 4)) : TW'($urandom);
      step(cl, ld, d, pe, te, "R2/R3/R4/R7 random");
    end

    // An asynchronous reset in the middle of a run.
    @(negedge clk); rst_n = 1'b0; #1;
    model = '0;
    check_cnt("R1 async reset", '0);
    @(negedge clk); rst_n = 1'b1; clear_n = 1'b1; load_n = 1'b0; load_data = 12'h777;
    @(posedge clk); #1 check_cnt("R1 load ignored in sync", '0);
    @(posedge clk); #1 check_cnt("R1 load ignored in sync", '0);
    step(1'b1, 1'b0, 12'h777, 1'b0, 1'b0, "R3 load after reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule